// File: doc/BRIEF.md
# Real-Mode Interrupt Vector Dispatcher

This block sits beside an instruction sequencer and converts interrupt requests into a jump target. Three sources can ask for service. The first is an exception or software-interrupt request that carries an 8-bit type. The second is a non-maskable input. The third is a level-sensitive maskable input whose type comes from an external controller. Requests are considered only when the sequencer strobes that the current instruction has finished.

At such a strobe the block picks one winner. It then reads that type's 4-byte entry from the vector table at the bottom of memory, using two word reads on a simple request/valid port. After the reads it presents the new segment, the new offset and the 20-bit physical target, together with a one-cycle completion pulse. Saving flags and the return address is done elsewhere.

Top module: `ivec_dispatch`

## Requirements
- R1: While reset is held and just after it, `busy_o`, `done_o` and `mem_req_o` are 0 and `new_cs_o`, `new_ip_o`, `phys_o`, `type_o` and `src_o` are all 0.
- R2: A dispatch of type T makes exactly two reads, in order: first at byte address T*4, then at T*4+2. The request and address stay stable until `mem_valid_i` is seen.
- R3: The word returned at T*4 appears on `new_ip_o` and the word at T*4+2 appears on `new_cs_o`. `done_o` is high for exactly one cycle, the cycle after the second word is accepted, and the outputs hold until the next dispatch.
- R4: When `done_o` is high, `phys_o` equals (`new_cs_o` * 16 + `new_ip_o`) modulo 2^20.
- R5: A non-maskable dispatch always uses type 2.
- R6: A rising edge on `nmi_i`, even one cycle long, is remembered until it is dispatched. A level held high after its dispatch causes no further dispatch.
- R7: `intr_i` is serviced only while `if_flag_i` is 1, using `intr_type_i`. When `if_flag_i` is 0 the input is ignored.
- R8: A request is accepted only in a cycle where `boundary_i` is high and the block is idle.
- R9: At a boundary the priority is exception/software (`src_o`=1) over non-maskable (`src_o`=2) over maskable (`src_o`=3). A source that loses stays pending and is served at a later boundary.
- R10: `busy_o` is high from the cycle after acceptance through the `done_o` cycle. Boundary strobes while busy start nothing.
- R11: The edge types 0 and 255 read addresses 0x000/0x002 and 0x3FC/0x3FE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary_i | input | 1 | Instruction-completed strobe |
| exc_req_i | input | 1 | Exception/software request level, held until accepted |
| exc_type_i | input | 8 | Type for exc_req_i |
| nmi_i | input | 1 | Non-maskable request, edge detected |
| intr_i | input | 1 | Maskable request level |
| intr_type_i | input | 8 | Type for intr_i |
| if_flag_i | input | 1 | Interrupt-enable flag |
| mem_req_o | output | 1 | Table read request |
| mem_addr_o | output | 20 | Table read byte address |
| mem_rdata_i | input | 16 | Read data word |
| mem_valid_i | input | 1 | Read data valid |
| busy_o | output | 1 | Dispatch in progress |
| done_o | output | 1 | One-cycle completion pulse |
| new_cs_o | output | 16 | New code segment |
| new_ip_o | output | 16 | New instruction pointer |
| phys_o | output | 20 | Physical target address |
| type_o | output | 8 | Type that was dispatched |
| src_o | output | 2 | Source that was dispatched (1 exc, 2 NMI, 3 maskable) |

## Verification
The hardest case is a boundary strobe that arrives while a fetch is still waiting on slow memory, with a maskable request already pending behind it. The stimulus holds the strobe high continuously and adds read latency. This shows that nothing is accepted mid-fetch and that the pending request is taken exactly at the first idle boundary after the pulse. A second hard case is a one-cycle NMI pulse arriving together with a higher-priority exception. The stimulus raises all three sources before a single strobe and then releases the winners one boundary at a time, so the latched edge has to survive a lost arbitration.

// File: rtl/ivec_pkg.sv
package ivec_pkg;
  localparam int TYPE_W    = 8;
  localparam int WORD_W    = 16;
  localparam int PADDR_W   = 20;
  localparam int SEG_SHIFT = 4;
  localparam logic [TYPE_W-1:0] NMI_TYPE = 8'd2;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_EXC  = 2'd1,
    SRC_NMI  = 2'd2,
    SRC_INTR = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    FS_IDLE  = 2'd0,
    FS_RD_IP = 2'd1,
    FS_RD_CS = 2'd2,
    FS_DONE  = 2'd3
  } fstate_e;

  // byte address of the offset word (hi=0) or segment word (hi=1)
  function automatic logic [PADDR_W-1:0] entry_addr(input logic [TYPE_W-1:0] t,
                                                    input logic hi);
    logic [PADDR_W-1:0] a;
    a = '0;
    a[TYPE_W+1:0] = {t, hi, 1'b0};
    return a;
  endfunction

  function automatic logic [PADDR_W-1:0] phys_of(input logic [WORD_W-1:0] seg,
                                                 input logic [WORD_W-1:0] off);
    logic [PADDR_W-1:0] s;
    logic [PADDR_W-1:0] o;
    s = PADDR_W'({seg, {SEG_SHIFT{1'b0}}});
    o = PADDR_W'(off);
    return s + o;
  endfunction
endpackage

// File: rtl/ivec_nmi_latch.sv
module ivec_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_i,
  input  logic clear_i,
  output logic pend_o
);
  logic nmi_q;
  logic nmi_edge;

  assign nmi_edge = nmi_i & ~nmi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_q  <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      nmi_q <= nmi_i;
      if (nmi_edge)     pend_o <= 1'b1;   // a fresh edge beats a clear
      else if (clear_i) pend_o <= 1'b0;
    end
  end

  p_nmi_catch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_i) |=> pend_o);
  p_nmi_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && !clear_i) |=> pend_o);
endmodule

// File: rtl/ivec_arbiter.sv
module ivec_arbiter
  import ivec_pkg::*;
(
  input  logic              exc_req_i,
  input  logic [TYPE_W-1:0] exc_type_i,
  input  logic              nmi_pend_i,
  input  logic              intr_i,
  input  logic [TYPE_W-1:0] intr_type_i,
  input  logic              if_flag_i,
  output logic              any_o,
  output src_e              src_o,
  output logic [TYPE_W-1:0] type_o
);
  logic intr_ok;
  assign intr_ok = intr_i & if_flag_i;

  always_comb begin
    src_o  = SRC_NONE;
    type_o = '0;
    if (exc_req_i) begin
      src_o  = SRC_EXC;
      type_o = exc_type_i;
    end else if (nmi_pend_i) begin
      src_o  = SRC_NMI;
      type_o = NMI_TYPE;
    end else if (intr_ok) begin
      src_o  = SRC_INTR;
      type_o = intr_type_i;
    end
  end

  assign any_o = (src_o != SRC_NONE);

  always_comb begin
    a_exc_first_r9: assert (!exc_req_i || src_o == SRC_EXC);
  end
endmodule

// File: rtl/ivec_fetch.sv
module ivec_fetch
  import ivec_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [TYPE_W-1:0]  start_type_i,
  input  src_e               start_src_i,
  output logic               mem_req_o,
  output logic [PADDR_W-1:0] mem_addr_o,
  input  logic [WORD_W-1:0]  mem_rdata_i,
  input  logic               mem_valid_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [WORD_W-1:0]  new_cs_o,
  output logic [WORD_W-1:0]  new_ip_o,
  output logic [PADDR_W-1:0] phys_o,
  output logic [TYPE_W-1:0]  type_o,
  output src_e               src_o
);
  fstate_e             state;
  logic [TYPE_W-1:0]   cur_type;
  src_e                cur_src;
  logic [WORD_W-1:0]   ip_q;
  logic                rd_ip_fire;
  logic                rd_cs_fire;

  assign mem_req_o  = (state == FS_RD_IP) || (state == FS_RD_CS);
  assign mem_addr_o = mem_req_o ? entry_addr(cur_type, state == FS_RD_CS) : '0;
  assign rd_ip_fire = (state == FS_RD_IP) && mem_valid_i;
  assign rd_cs_fire = (state == FS_RD_CS) && mem_valid_i;
  assign busy_o     = (state != FS_IDLE);
  assign done_o     = (state == FS_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= FS_IDLE;
      cur_type <= '0;
      cur_src  <= SRC_NONE;
      ip_q     <= '0;
      new_cs_o <= '0;
      new_ip_o <= '0;
      phys_o   <= '0;
      type_o   <= '0;
      src_o    <= SRC_NONE;
    end else begin
      unique case (state)
        FS_IDLE: if (start_i) begin
          cur_type <= start_type_i;
          cur_src  <= start_src_i;
          state    <= FS_RD_IP;
        end
        FS_RD_IP: if (rd_ip_fire) begin
          ip_q  <= mem_rdata_i;
          state <= FS_RD_CS;
        end
        FS_RD_CS: if (rd_cs_fire) begin
          new_cs_o <= mem_rdata_i;
          new_ip_o <= ip_q;
          phys_o   <= phys_of(mem_rdata_i, ip_q);
          type_o   <= cur_type;
          src_o    <= cur_src;
          state    <= FS_DONE;
        end
        FS_DONE: state <= FS_IDLE;
        default: state <= FS_IDLE;
      endcase
    end
  end

  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));
  p_cs_follows_ip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_valid_i && !mem_addr_o[1]) |=>
      (mem_req_o && mem_addr_o == $past(mem_addr_o) + PADDR_W'(2)));
  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_after_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(mem_req_o && mem_valid_i && mem_addr_o[1]));
  p_phys_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (phys_o == (PADDR_W'(new_cs_o) << 4) + PADDR_W'(new_ip_o)));
  p_busy_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);
endmodule

// File: rtl/ivec_dispatch.sv
module ivec_dispatch
  import ivec_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               boundary_i,
  input  logic               exc_req_i,
  input  logic [7:0]         exc_type_i,
  input  logic               nmi_i,
  input  logic               intr_i,
  input  logic [7:0]         intr_type_i,
  input  logic               if_flag_i,
  output logic               mem_req_o,
  output logic [19:0]        mem_addr_o,
  input  logic [15:0]        mem_rdata_i,
  input  logic               mem_valid_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [15:0]        new_cs_o,
  output logic [15:0]        new_ip_o,
  output logic [19:0]        phys_o,
  output logic [7:0]         type_o,
  output logic [1:0]         src_o
);
  logic              nmi_pend;
  logic              win_any;
  src_e              win_src;
  logic [TYPE_W-1:0] win_type;
  logic              accept;
  logic              nmi_taken;
  src_e              done_src;

  assign accept    = boundary_i && !busy_o && win_any;
  assign nmi_taken = accept && (win_src == SRC_NMI);

  ivec_nmi_latch u_nmi (
    .clk    (clk),
    .rst_n  (rst_n),
    .nmi_i  (nmi_i),
    .clear_i(nmi_taken),
    .pend_o (nmi_pend)
  );

  ivec_arbiter u_arb (
    .exc_req_i  (exc_req_i),
    .exc_type_i (exc_type_i),
    .nmi_pend_i (nmi_pend),
    .intr_i     (intr_i),
    .intr_type_i(intr_type_i),
    .if_flag_i  (if_flag_i),
    .any_o      (win_any),
    .src_o      (win_src),
    .type_o     (win_type)
  );

  ivec_fetch u_fetch (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (accept),
    .start_type_i(win_type),
    .start_src_i (win_src),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_rdata_i (mem_rdata_i),
    .mem_valid_i (mem_valid_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .new_cs_o    (new_cs_o),
    .new_ip_o    (new_ip_o),
    .phys_o      (phys_o),
    .type_o      (type_o),
    .src_o       (done_src)
  );

  assign src_o = done_src;

  p_accept_at_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(boundary_i));
  p_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary_i && !busy_o && !exc_req_i && !nmi_pend && !(intr_i && if_flag_i))
      |=> !busy_o);
  p_nmi_type_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && src_o == 2'd2) |-> (type_o == 8'd2));
endmodule

// File: tb/ivec_dispatch_tb.sv
module ivec_dispatch_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boundary_i = 1'b0;
  logic exc_req_i = 1'b0;
  logic [7:0] exc_type_i = '0;
  logic nmi_i = 1'b0;
  logic intr_i = 1'b0;
  logic [7:0] intr_type_i = '0;
  logic if_flag_i = 1'b0;
  logic mem_req_o;
  logic [19:0] mem_addr_o;
  logic [15:0] mem_rdata_i = '0;
  logic mem_valid_i = 1'b0;
  logic busy_o, done_o;
  logic [15:0] new_cs_o, new_ip_o;
  logic [19:0] phys_o;
  logic [7:0] type_o;
  logic [1:0] src_o;

  always #2 clk = ~clk;

  ivec_dispatch u_dut (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i),
    .exc_req_i(exc_req_i), .exc_type_i(exc_type_i), .nmi_i(nmi_i),
    .intr_i(intr_i), .intr_type_i(intr_type_i), .if_flag_i(if_flag_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i),
    .mem_valid_i(mem_valid_i), .busy_o(busy_o), .done_o(done_o),
    .new_cs_o(new_cs_o), .new_ip_o(new_ip_o), .phys_o(phys_o),
    .type_o(type_o), .src_o(src_o)
  );

  typedef struct packed {
    logic [7:0] t;
    logic [1:0] s;
  } exp_t;

  exp_t        sb_q[$];
  logic [19:0] addr_log[$];
  int n_run = 0;
  int n_fail = 0;
  int n_done = 0;
  int lat = 0;
  int cnt = 0;
  bit finished = 0;

  function automatic logic [15:0] mword(input logic [19:0] a);
    logic [19:0] p;
    p = a * 20'd40503;
    return p[15:0] ^ 16'hA5C3;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // memory model: answers after lat cycles, one word per request
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_valid_i = 1'b0;
      cnt = 0;
    end else if (mem_valid_i) begin
      mem_valid_i = 1'b0;
      cnt = 0;
    end else if (mem_req_o) begin
      if (cnt >= lat) begin
        mem_valid_i = 1'b1;
        mem_rdata_i = mword(mem_addr_o);
        addr_log.push_back(mem_addr_o);
      end else cnt++;
    end
  end

  // monitor: pops expected item on each completion pulse
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      n_done++;
      if (sb_q.size() == 0) begin
        chk(1'b0, "R8", "unexpected dispatch type", {24'd0, type_o}, 32'd0);
      end else begin
        exp_t e;
        logic [19:0] a0, a1, base;
        logic [15:0] eip, ecs;
        logic [31:0] ephys;
        e = sb_q.pop_front();
        base = {10'd0, e.t, 2'b00};
        eip = mword(base);
        ecs = mword(base + 20'd2);
        ephys = ({16'd0, ecs} << 4) + {16'd0, eip};
        chk(type_o == e.t, "R9", "dispatched type", {24'd0, type_o}, {24'd0, e.t});
        chk(src_o == e.s, "R9", "dispatched source", {30'd0, src_o}, {30'd0, e.s});
        chk(new_ip_o == eip, "R3", "new IP", {16'd0, new_ip_o}, {16'd0, eip});
        chk(new_cs_o == ecs, "R3", "new CS", {16'd0, new_cs_o}, {16'd0, ecs});
        chk(phys_o == ephys[19:0], "R4", "physical target", {12'd0, phys_o}, {12'd0, ephys[19:0]});
        chk(busy_o, "R10", "busy during done", {31'd0, busy_o}, 32'd1);
        if (addr_log.size() >= 2) begin
          a0 = addr_log.pop_front();
          a1 = addr_log.pop_front();
          chk(a0 == base, "R2", "first read address", {12'd0, a0}, {12'd0, base});
          chk(a1 == base + 20'd2, "R2", "second read address", {12'd0, a1}, {12'd0, base + 20'd2});
        end else begin
          chk(1'b0, "R2", "read count", addr_log.size(), 32'd2);
        end
      end
    end
  end

  task automatic drain();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (sb_q.size() == 0 && !busy_o) break;
    end
    chk(sb_q.size() == 0 && !busy_o, "R3", "dispatch completes", sb_q.size(), 32'd0);
  endtask

  task automatic push(input logic [7:0] t, input logic [1:0] s);
    exp_t e;
    e.t = t;
    e.s = s;
    sb_q.push_back(e);
  endtask

  task automatic strobe();
    boundary_i = 1'b1;
    @(negedge clk);
    boundary_i = 1'b0;
  endtask

  task automatic do_exc(input logic [7:0] t);
    exc_req_i = 1'b1;
    exc_type_i = t;
    push(t, 2'd1);
    strobe();
    exc_req_i = 1'b0;
    drain();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R3", "watchdog expired", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    int d0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(!busy_o && !done_o && !mem_req_o, "R1", "control outputs in reset",
        {29'd0, busy_o, done_o, mem_req_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(new_cs_o == 0 && new_ip_o == 0 && phys_o == 0 && type_o == 0 && src_o == 0,
        "R1", "data outputs after reset", {12'd0, phys_o}, 32'd0);

    // R2/R3/R4: software types, varied latency
    lat = 0; do_exc(8'h21);
    lat = 3; do_exc(8'h13);
    // R11: edge types
    lat = 1; do_exc(8'h00);
    lat = 2; do_exc(8'hFF);

    // R8: request without boundary is not taken
    lat = 0;
    exc_req_i = 1'b1; exc_type_i = 8'h07;
    d0 = n_done;
    repeat (10) @(negedge clk);
    chk(!busy_o && !mem_req_o && n_done == d0, "R8", "no accept without boundary",
        {31'd0, busy_o}, 32'd0);
    exc_req_i = 1'b0;

    // R5/R6: one-cycle NMI pulse, dispatched later as type 2
    nmi_i = 1'b1; @(negedge clk); nmi_i = 1'b0;
    repeat (5) @(negedge clk);
    push(8'd2, 2'd2); strobe(); drain();
    d0 = n_done;
    strobe(); repeat (6) @(negedge clk);
    chk(n_done == d0 && !busy_o, "R6", "no second NMI without new edge", n_done - d0, 32'd0);
    // R6: NMI held high dispatches once
    nmi_i = 1'b1; repeat (2) @(negedge clk);
    push(8'd2, 2'd2); strobe(); drain();
    d0 = n_done;
    strobe(); repeat (6) @(negedge clk);
    chk(n_done == d0, "R6", "held NMI dispatches once", n_done - d0, 32'd0);
    nmi_i = 1'b0;

    // R7: masked maskable input ignored
    intr_i = 1'b1; intr_type_i = 8'h48; if_flag_i = 1'b0;
    d0 = n_done;
    strobe(); repeat (6) @(negedge clk);
    chk(n_done == d0 && !busy_o && !mem_req_o, "R7", "masked input ignored",
        {31'd0, busy_o}, 32'd0);
    if_flag_i = 1'b1;
    push(8'h48, 2'd3); strobe(); drain();
    intr_i = 1'b0;

    // R9: all three at one boundary, served one per boundary
    exc_req_i = 1'b1; exc_type_i = 8'h30;
    intr_i = 1'b1; intr_type_i = 8'h41;
    nmi_i = 1'b1; @(negedge clk); nmi_i = 1'b0;
    @(negedge clk);
    push(8'h30, 2'd1); strobe(); exc_req_i = 1'b0; drain();
    push(8'd2, 2'd2); strobe(); drain();
    push(8'h41, 2'd3); strobe(); drain();
    intr_i = 1'b0;

    // R10: boundary held through a slow fetch, maskable waits
    lat = 3;
    exc_req_i = 1'b1; exc_type_i = 8'h55;
    intr_i = 1'b1; intr_type_i = 8'h66;
    push(8'h55, 2'd1); push(8'h66, 2'd3);
    d0 = n_done;
    boundary_i = 1'b1;
    @(negedge clk);
    exc_req_i = 1'b0;
    for (int i = 0; i < 100; i++) begin
      if (n_done != d0) break;
      @(negedge clk);
    end
    @(negedge clk);
    @(negedge clk);
    intr_i = 1'b0; boundary_i = 1'b0;
    drain();
    chk(n_done == d0 + 2, "R10", "two dispatches under held boundary", n_done - d0, 32'd2);
    if_flag_i = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule